// File: doc/BRIEF.md
# External Sync Presence Detector

This block judges whether an external horizontal sync stream is alive. It counts the rising edges of a sync input. A window tick comes from the internal timebase, and each tick closes one observation window. At every tick the block compares the number of edges in the closing window with a threshold. It then publishes the result on a single presence flag, which the surrounding logic can use to choose between external and internal synchronization.

The threshold comes from a one-hot selection code held in a sync-control register. Each bit of the code selects a power-of-two pulse count. An all-zero code switches detection off. The sync input is asynchronous, so it passes through a synchronizer before edge detection. The control pins are plain levels and pulses with no handshake.

Top module: `sync_presence_detector`

## Requirements
- R1: While reset is asserted and after reset is released, `sync_present` is low and the internal copy of the selection code is all-zero, so detection is disabled until a code is applied.
- R2: Code bit i alone selects a threshold of 2^(BASE_LOG2+i) pulses. With the defaults (BASE_LOG2=4), code 4'b0001 selects 16, 4'b0010 selects 32, 4'b0100 selects 64 and 4'b1000 selects 128.
- R3: While the registered code is 4'b0000, `sync_present` is driven low and the pulse counter is held at zero. Pulses arriving in that time have no effect on any later window.
- R4: When more than one code bit is set, only the highest set bit decides the threshold.
- R5: One count is added for each low-to-high transition of the synchronized `sync_in`. A level held high for many cycles counts once.
- R6: On a cycle with `win_tick` high, `sync_present` takes the value (count >= threshold) and the counter restarts for the next window. A sync edge detected in the tick cycle is counted toward the new window.
- R7: `sync_present` changes only on a window tick, or when detection is disabled.
- R8: The counter saturates at all-ones and does not wrap, so a window with more pulses than the counter can hold still reports presence.
- R9: A new code takes effect one cycle after it is applied. A `sync_in` rise reaches the counter SYNC_STAGES+1 clock edges after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | External horizontal sync, asynchronous |
| win_tick | input | 1 | One-cycle pulse closing the current window |
| thr_code | input | NUM_CODES | One-hot threshold selection; all-zero disables |
| sync_present | output | 1 | High when external sync is judged present |

## Verification
The bench builds the detector with BASE_LOG2=2, NUM_CODES=4 and SYNC_STAGES=2. With these values the four thresholds are 4, 8, 16 and 32 pulses, and the counter is 6 bits wide. Every threshold can then be probed one pulse below and exactly at its value within a short run. Saturation at 63 can also be tested: a window of 66 pulses would wrap a non-saturating counter to 2, which is below the 32-pulse threshold and shows up as a missing flag.

// File: rtl/sync_det_pkg.sv
package sync_det_pkg;

  // Threshold for one code bit position.
  function automatic int unsigned bit_threshold(input int unsigned base_log2,
                                                input int unsigned idx);
    return 32'd1 << (base_log2 + idx);
  endfunction

endpackage

// File: rtl/sync_edge_detect.sv
module sync_edge_detect #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_in};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign rise = chain_q[STAGES-1] & ~last_q;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);  // R5

endmodule

// File: rtl/sync_thr_decode.sv
module sync_thr_decode
  import sync_det_pkg::*;
#(
  parameter int unsigned BASE_LOG2 = 4,
  parameter int unsigned NUM_CODES = 4,
  localparam int unsigned CNT_W = BASE_LOG2 + NUM_CODES
) (
  input  logic [NUM_CODES-1:0] code,
  output logic [CNT_W-1:0]     thr,
  output logic                 enable
);

  logic [NUM_CODES-1:0][CNT_W-1:0] cand;

  for (genvar gi = 0; gi < NUM_CODES; gi++) begin : g_cand
    assign cand[gi] = CNT_W'(bit_threshold(BASE_LOG2, gi));
  end

  // Ascending scan: the highest set bit is the last to assign.
  always_comb begin
    thr = '0;
    for (int i = 0; i < NUM_CODES; i++) begin
      if (code[i]) thr = cand[i];
    end
  end

  assign enable = |code;

endmodule

// File: rtl/sync_pulse_counter.sv
module sync_pulse_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (!enable) begin
      count <= '0;
    end else if (clr) begin
      count <= inc ? CNT_W'(1) : '0;
    end else if (inc && count != CNT_MAX) begin
      count <= count + 1'b1;
    end
  end

  AST_HELD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> count == '0);  // R3
  AST_WINDOW_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && clr && !inc) |=> count == '0);  // R6
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !clr && inc && count != CNT_MAX) |=> count == $past(count) + 1'b1);  // R5
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !clr && count == CNT_MAX) |=> count == CNT_MAX);  // R8

endmodule

// File: rtl/sync_presence_detector.sv
module sync_presence_detector #(
  parameter int unsigned BASE_LOG2   = 4,
  parameter int unsigned NUM_CODES   = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sync_in,
  input  logic                 win_tick,
  input  logic [NUM_CODES-1:0] thr_code,
  output logic                 sync_present
);

  localparam int unsigned CNT_W = BASE_LOG2 + NUM_CODES;

  logic [NUM_CODES-1:0] code_q;
  logic [CNT_W-1:0]     thr;
  logic [CNT_W-1:0]     count;
  logic                 det_en;
  logic                 rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= thr_code;
  end

  sync_edge_detect #(.STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (sync_in),
    .rise     (rise)
  );

  sync_thr_decode #(.BASE_LOG2(BASE_LOG2), .NUM_CODES(NUM_CODES)) u_dec (
    .code   (code_q),
    .thr    (thr),
    .enable (det_en)
  );

  sync_pulse_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (det_en),
    .inc    (rise),
    .clr    (win_tick),
    .count  (count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sync_present <= 1'b0;
    else if (!det_en)  sync_present <= 1'b0;
    else if (win_tick) sync_present <= (count >= thr);
  end

  AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q == '0) |=> !sync_present);  // R3
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_tick && det_en) |=> $stable(sync_present));  // R7
  AST_CODE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> code_q == $past(thr_code));  // R9

endmodule

// File: tb/sync_presence_detector_tb.sv
module sync_presence_detector_tb;

  localparam int unsigned BASE_LOG2 = 2;
  localparam int unsigned NUM_CODES = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync_in = 1'b0;
  logic       win_tick = 1'b0;
  logic [3:0] thr_code = 4'b0000;
  logic       sync_present;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sync_presence_detector #(
    .BASE_LOG2(BASE_LOG2), .NUM_CODES(NUM_CODES), .SYNC_STAGES(2)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .win_tick(win_tick),
    .thr_code(thr_code), .sync_present(sync_present)
  );

  task automatic check(input string req, input logic exp);
    checks++;
    if (sync_present !== exp) begin
      failures++;
      $display("FAIL %s: sync_present=%b expected=%b", req, sync_present, exp);
    end
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      sync_in = 1'b1;
      repeat (2) @(negedge clk);
      sync_in = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic tick();
    repeat (4) @(negedge clk);
    win_tick = 1'b1;
    @(negedge clk);
    win_tick = 1'b0;
  endtask

  task automatic set_code(input logic [3:0] c);
    thr_code = c;
    repeat (2) @(negedge clk);
    tick();
  endtask

  task automatic window(input int n, input logic exp, input string req);
    pulses(n);
    tick();
    check(req, exp);
  endtask

  task automatic t_reset();
    check("R1 in reset", 1'b0);
    rst_n = 1'b1;
    pulses(10);
    tick();
    check("R1 disabled after reset", 1'b0);
  endtask

  task automatic t_thresholds();
    set_code(4'b0001);
    window(3, 1'b0, "R2 code0001 below 4");
    window(4, 1'b1, "R2 code0001 at 4");
    window(3, 1'b0, "R6 counter restarts");
    set_code(4'b0010);
    window(7, 1'b0, "R2 code0010 below 8");
    window(8, 1'b1, "R2 code0010 at 8");
    set_code(4'b0100);
    window(15, 1'b0, "R2 code0100 below 16");
    window(16, 1'b1, "R2 code0100 at 16");
    set_code(4'b1000);
    window(31, 1'b0, "R2 code1000 below 32");
    window(32, 1'b1, "R2 code1000 at 32");
  endtask

  task automatic t_hold();
    set_code(4'b0001);
    window(5, 1'b1, "R7 setup");
    pulses(0);
    repeat (30) @(negedge clk);
    check("R7 held high without tick", 1'b1);
    pulses(1);
    tick();
    check("R7 low at tick", 1'b0);
    pulses(6);
    check("R7 stays low before tick", 1'b0);
  endtask

  task automatic t_multi();
    set_code(4'b0011);
    window(4, 1'b0, "R4 low bit ignored");
    window(8, 1'b1, "R4 highest bit used");
  endtask

  task automatic t_disable();
    set_code(4'b0001);
    window(5, 1'b1, "R3 setup");
    thr_code = 4'b0000;
    repeat (3) @(negedge clk);
    check("R3 flag forced low", 1'b0);
    pulses(40);
    tick();
    check("R3 disabled window", 1'b0);
    thr_code = 4'b0001;
    repeat (2) @(negedge clk);
    window(3, 1'b0, "R3 no carried counts");
  endtask

  task automatic t_level();
    set_code(4'b0001);
    sync_in = 1'b1;
    repeat (20) @(negedge clk);
    sync_in = 1'b0;
    repeat (2) @(negedge clk);
    window(2, 1'b0, "R5 held level counts once");
  endtask

  task automatic t_saturate();
    set_code(4'b1000);
    window(66, 1'b1, "R8 saturation no wrap");
  endtask

  task automatic t_latency();
    set_code(4'b0001);
    sync_in = 1'b1;
    @(negedge clk);
    sync_in = 1'b0;
    @(negedge clk);
    win_tick = 1'b1;
    @(negedge clk);
    win_tick = 1'b0;
    window(3, 1'b1, "R9 edge in tick cycle counted in new window (R6)");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_thresholds();
    t_hold();
    t_multi();
    t_disable();
    t_level();
    t_saturate();
    t_latency();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: expired expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule